// File: doc/BRIEF.md
# Backplane Row Sequencer with Wired Frame Alignment

This block paces the refresh of a multiplexed segment display. A slot timer divides the clock into backplane slots of `SLOT_DIV` cycles. A row counter visits only the rows that the selected multiplex ratio uses. For the row being driven, the block picks one stored bit per segment out of a four-bit memory word and presents the on/off vector for that row. A blink gate can blank the whole vector on alternate periods counted in frames.

Several copies can share one wired alignment line. Each copy pulls the line for the whole of its final slot and watches it in every other slot. A copy that sees the line pulled early jumps to its final slot, so all copies start row 0 on the same edge. Multiplex ratio, bank choice and blink rate are sampled only when a frame ends.

Top module: `bp_frame_seq`

## Requirements
- R1: After reset the block shows row 0 with the single-row configuration, bank 0 and blink off, the pull output is high, and each segment shows memory bit 0.
- R2: `mux_sel` 0, 1, 2 and 3 select 1, 2, 3 and 4 rows. The row index moves up by one every `SLOT_DIV` cycles and returns to 0 after the highest used row.
- R3: With one row, segment s shows `ram_bits[4*s+0]` when the bank is 0 and `ram_bits[4*s+2]` when the bank is 1.
- R4: With two rows, rows 0 and 1 show bits 0 and 1 of each word when the bank is 0, and bits 2 and 3 when the bank is 1.
- R5: With three or four rows, row r shows bit r of each word, whatever the bank input.
- R6: Changes on `mux_sel`, `bank_sel` and `blink_sel` take effect only on the edge that ends a frame, never in the middle of one.
- R7: `sync_pull` is high exactly while the row index is the highest used row.
- R8: If `sync_seen` is high in a cycle where the row is not the highest used row, then on the next edge the row becomes the highest used row, and that slot ends `SLOT_DIV-1` cycles later.
- R9: `sync_seen` has no effect while the row is already the highest used row.
- R10: `blink_sel` 0 disables blanking. Values 1, 2 and 3 blank every segment while bit `BLINK_LSB+3-blink_sel` of a frame count is 1. The frame count is 0 after reset and increments at each frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mux_sel | input | 2 | Multiplex ratio: rows used minus one |
| bank_sel | input | 1 | Memory bank choice for the one- and two-row ratios |
| blink_sel | input | 2 | Blink rate; 0 disables blinking, 1 is the slowest |
| ram_bits | input | 4*NUM_SEG | Display memory, four bits per segment |
| sync_seen | input | 1 | Sensed state of the shared alignment line, high when pulled |
| row_idx | output | 2 | Backplane row being driven |
| seg_on | output | NUM_SEG | On/off state of each segment for the current row |
| sync_pull | output | 1 | Request to pull the shared alignment line |

## Verification
`row_idx` and `sync_pull` are registered. They change on the slot-ending edge, or on the edge right after the line is seen for a jump. `seg_on` follows those registers and `ram_bits` within the same cycle. New settings appear in the slot that starts on the edge ending the frame. The driver advances a requirement-level model exactly at each slot-start edge and queues the expected row, segment vector and pull state. The monitor compares them at the next falling edge, so every sample falls half a cycle after the register update it depends on.

// File: rtl/bp_seq_pkg.sv
package bp_seq_pkg;

    typedef enum logic [1:0] {
        MUX_ONE   = 2'd0,
        MUX_TWO   = 2'd1,
        MUX_THREE = 2'd2,
        MUX_FOUR  = 2'd3
    } mux_e;

    typedef struct packed {
        mux_e       mux;
        logic       bank;
        logic [1:0] blink;
    } seq_cfg_t;

    // highest row index in use equals the ratio code
    function automatic logic [1:0] top_row(input mux_e m);
        return m;
    endfunction

endpackage

// File: rtl/bp_slot_timer.sv
module bp_slot_timer
    import bp_seq_pkg::*;
#(
    parameter int SLOT_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  seq_cfg_t   cfg_in,
    input  logic       sync_seen,
    output logic [1:0] row_q,
    output seq_cfg_t   cfg_q,
    output logic       frame_end,
    output logic       sync_pull
);
    localparam int DW = (SLOT_DIV > 2) ? $clog2(SLOT_DIV) : 1;
    localparam logic [DW-1:0] DIV_END = DW'(SLOT_DIV - 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [1:0]    row;
        seq_cfg_t      cfg;
        logic          pull;
    } tmr_t;

    tmr_t st_d, st_q;
    logic slot_end_w, at_top_w, jump_w;

    always_comb begin
        st_d       = st_q;
        slot_end_w = (st_q.div == DIV_END);
        at_top_w   = (st_q.row == top_row(st_q.cfg.mux));
        jump_w     = sync_seen && !at_top_w;
        if (jump_w) begin
            // act as if this cycle opened the final slot
            st_d.row = top_row(st_q.cfg.mux);
            st_d.div = DW'(1);
        end else if (slot_end_w) begin
            st_d.div = '0;
            if (at_top_w) begin
                st_d.row = 2'd0;
                st_d.cfg = cfg_in;
            end else begin
                st_d.row = st_q.row + 2'd1;
            end
        end else begin
            st_d.div = st_q.div + DW'(1);
        end
        st_d.pull = (st_d.row == top_row(st_d.cfg.mux));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{div: '0, row: 2'd0,
                      cfg: '{mux: MUX_ONE, bank: 1'b0, blink: 2'd0},
                      pull: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign row_q     = st_q.row;
    assign cfg_q     = st_q.cfg;
    assign sync_pull = st_q.pull;
    assign frame_end = slot_end_w && at_top_w;

endmodule

// File: rtl/bp_blink_gate.sv
module bp_blink_gate #(
    parameter int BLINK_LSB = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_end,
    input  logic [1:0] blink,
    output logic       blank
);
    localparam int FW = BLINK_LSB + 3;

    typedef struct packed {
        logic [FW-1:0] fcnt;
    } blk_t;

    blk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.fcnt = st_q.fcnt + FW'(1);
        end
    end

    always_comb begin
        blank = 1'b0;
        for (int k = 1; k < 4; k++) begin
            if (blink == 2'(k)) begin
                blank = st_q.fcnt[BLINK_LSB + 3 - k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fcnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bp_seg_select.sv
module bp_seg_select
    import bp_seq_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  logic [4*NUM_SEG-1:0] ram_bits,
    input  logic [1:0]           row,
    input  mux_e                 mux,
    input  logic                 bank,
    input  logic                 blank,
    output logic [NUM_SEG-1:0]   seg_on
);
    logic [1:0] bit_sel;

    always_comb begin
        unique case (mux)
            MUX_ONE: bit_sel = {bank, 1'b0};
            MUX_TWO: bit_sel = {bank, row[0]};
            default: bit_sel = row;
        endcase
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [3:0] word;
        assign word      = ram_bits[4*s +: 4];
        assign seg_on[s] = !blank && word[bit_sel];
    end

endmodule

// File: rtl/bp_frame_seq.sv
module bp_frame_seq
    import bp_seq_pkg::*;
#(
    parameter int NUM_SEG   = 8,
    parameter int SLOT_DIV  = 4,
    parameter int BLINK_LSB = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mux_sel,
    input  logic                 bank_sel,
    input  logic [1:0]           blink_sel,
    input  logic [4*NUM_SEG-1:0] ram_bits,
    input  logic                 sync_seen,
    output logic [1:0]           row_idx,
    output logic [NUM_SEG-1:0]   seg_on,
    output logic                 sync_pull
);
    seq_cfg_t req_cfg, act_cfg;
    logic     frame_end, blank;

    assign req_cfg = '{mux: mux_e'(mux_sel), bank: bank_sel, blink: blink_sel};

    bp_slot_timer #(.SLOT_DIV(SLOT_DIV)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_in    (req_cfg),
        .sync_seen (sync_seen),
        .row_q     (row_idx),
        .cfg_q     (act_cfg),
        .frame_end (frame_end),
        .sync_pull (sync_pull)
    );

    bp_blink_gate #(.BLINK_LSB(BLINK_LSB)) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .blink     (act_cfg.blink),
        .blank     (blank)
    );

    bp_seg_select #(.NUM_SEG(NUM_SEG)) u_sel (
        .ram_bits (ram_bits),
        .row      (row_idx),
        .mux      (act_cfg.mux),
        .bank     (act_cfg.bank),
        .blank    (blank),
        .seg_on   (seg_on)
    );

endmodule

// File: rtl/bp_frame_seq_chk.sv
module bp_frame_seq_chk
    import bp_seq_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         row_idx,
    input logic [NUM_SEG-1:0] seg_on,
    input logic               sync_pull,
    input logic               sync_seen,
    input seq_cfg_t           act_cfg,
    input logic               frame_end,
    input logic               blank
);
    a_r2_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= top_row(act_cfg.mux));

    a_r7_pull_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pull == (row_idx == top_row(act_cfg.mux)));

    a_r6_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(act_cfg));

    a_r8_jump_to_top: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_seen && !sync_pull) |=> sync_pull);

    a_r10_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (seg_on == '0));

endmodule

bind bp_frame_seq bp_frame_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_idx   (row_idx),
    .seg_on    (seg_on),
    .sync_pull (sync_pull),
    .sync_seen (sync_seen),
    .act_cfg   (act_cfg),
    .frame_end (frame_end),
    .blank     (blank)
);

// File: tb/tb_bp_frame_seq.sv
module tb_bp_frame_seq;
    localparam int NS  = 8;
    localparam int D   = 4;
    localparam int BL  = 1;
    localparam logic [4*NS-1:0] RAM = 32'hC93A_5E71;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mux_sel = 2'd0;
    logic          bank_sel = 1'b0;
    logic [1:0]    blink_sel = 2'd0;
    logic          oth = 1'b0;
    logic          sync_line;
    logic [1:0]    row_idx;
    logic [NS-1:0] seg_on;
    logic          sync_pull;

    assign sync_line = oth | sync_pull;

    bp_frame_seq #(.NUM_SEG(NS), .SLOT_DIV(D), .BLINK_LSB(BL)) dut (
        .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .bank_sel(bank_sel),
        .blink_sel(blink_sel), .ram_bits(RAM), .sync_seen(sync_line),
        .row_idx(row_idx), .seg_on(seg_on), .sync_pull(sync_pull)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            row;
        logic [NS-1:0] seg;
        logic          pull;
        string         tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state, built from the requirements
    int m_row = 0, m_md = 0, m_bk = 0, m_bl = 0, m_fc = 0;
    int i_md = 0, i_bk = 0, i_bl = 0;

    function automatic logic [NS-1:0] exp_seg(int md, int bk, int row, bit blk);
        logic [NS-1:0] r;
        int b;
        if (md == 0)      b = bk ? 2 : 0;
        else if (md == 1) b = (bk ? 2 : 0) + row;
        else              b = row;
        for (int s = 0; s < NS; s++) r[s] = blk ? 1'b0 : RAM[4*s + b];
        return r;
    endfunction

    function automatic bit m_blank();
        if (m_bl == 0) return 1'b0;
        return 1'((m_fc >> (BL + 3 - m_bl)) & 1);
    endfunction

    task automatic push(input string tag);
        item_t it;
        it.row  = m_row;
        it.seg  = exp_seg(m_md, m_bk, m_row, m_blank());
        it.pull = (m_row == m_md);
        it.tag  = tag;
        q.push_back(it);
    endtask

    // called one ns after a slot-start edge
    task automatic run_slot(input int md, input int bk, input int bl,
                            input bit jmp, input bit first, input string tag);
        if (!first) begin
            if (m_row == m_md) begin
                m_row = 0; m_md = i_md; m_bk = i_bk; m_bl = i_bl; m_fc++;
            end else begin
                m_row++;
            end
        end
        push(tag);
        i_md = md; i_bk = bk; i_bl = bl;
        mux_sel = 2'(md); bank_sel = 1'(bk); blink_sel = 2'(bl);
        if (jmp) begin
            oth = 1'b1;
            @(posedge clk); #1;
            oth = 1'b0;
            if (m_row != m_md) m_row = m_md;
            push(tag);
            repeat (D - 1) @(posedge clk);
            #1;
        end else begin
            repeat (D) @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor
    initial begin
        item_t it;
        forever begin
            wait (q.size() > 0);
            @(negedge clk);
            it = q.pop_front();
            chk(int'(row_idx) == it.row, it.tag, "row_idx", int'(row_idx), it.row);
            chk(seg_on == it.seg, it.tag, "seg_on", int'(seg_on), int'(it.seg));
            chk(sync_pull == it.pull, "R7", "sync_pull", int'(sync_pull), int'(it.pull));
        end
    end

    // driver
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        run_slot(0, 1, 0, 0, 1, "R1");      // reset view, request bank 1
        run_slot(0, 0, 0, 0, 0, "R3");      // bank 1 -> bit 2
        run_slot(1, 0, 0, 0, 0, "R3");      // bank 0 -> bit 0, request two rows
        run_slot(1, 1, 0, 0, 0, "R4");      // two rows, row 0, bank 0
        run_slot(1, 1, 0, 0, 0, "R6");      // row 1 still on bank 0
        run_slot(1, 1, 0, 0, 0, "R4");      // row 0 bank 1
        run_slot(2, 1, 0, 0, 0, "R4");      // row 1 bank 1, request three rows
        for (int k = 0; k < 5; k++) run_slot(2, 1, 0, 0, 0, "R5");
        run_slot(3, 1, 0, 0, 0, "R5");      // last three-row slot, request four
        for (int k = 0; k < 5; k++) run_slot(3, 0, 0, 0, 0, "R2");
        run_slot(3, 0, 0, 1, 0, "R8");      // row 1, line seen -> jump
        run_slot(3, 0, 0, 0, 0, "R8");      // frame restarts at row 0
        run_slot(3, 0, 0, 0, 0, "R2");
        run_slot(3, 0, 0, 0, 0, "R2");
        run_slot(3, 0, 0, 1, 0, "R9");      // line seen on top row: no change
        run_slot(0, 0, 3, 0, 0, "R9");
        for (int k = 0; k < 3; k++) run_slot(0, 0, 3, 0, 0, "R6");
        for (int k = 0; k < 9; k++) run_slot(0, 0, 3, 0, 0, "R10");
        run_slot(0, 1, 1, 0, 0, "R10");
        for (int k = 0; k < 18; k++) run_slot(0, 1, 1, 0, 0, "R10");
        run_slot(0, 1, 0, 0, 0, "R10");
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            bad++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule